// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Read Mode

This block is a first-in first-out buffer between two clock domains. Words enter on the rising edge of the write clock when the write enable is high. Words leave on the rising edge of the read clock. The two clocks run freely and need no fixed relation. The write and read pointers pass between the domains as Gray code through two-flop synchronizers. Full, almost-full and half-full are computed on the write side. Empty, output-ready and almost-empty are computed on the read side.

A static mode input sets how the read port behaves. In standard mode a word moves to the output register only when read enable is high on a read-clock edge. In fall-through mode the head word moves to the output on its own, and read enable takes it away. The two status outputs mean different things in the two modes. The mode input is changed only while reset is held.

The almost-empty and almost-full thresholds come from a short load sequence. The load input is held together with write enable, and each cycle takes its value from the write data bus. An output enable forces the data output to zero when it is low.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave in the order they were written, with their values unchanged. Each pointer crosses clock domains as Gray code and changes by at most one bit per clock.
- R2: In standard mode, rd_stat_o is the empty flag (1 = no word stored). rdata_o loads the next word only on a read-clock edge where rd_en_i is high and the FIFO is not empty. Otherwise rdata_o holds its value.
- R3: In fall-through mode, rd_stat_o is output-ready (1 = a valid word is on rdata_o). The first word written into an empty FIFO appears on rdata_o, with rd_stat_o high, on the third rising read-clock edge after the write edge. No read enable is needed for this.
- R4: wr_stat_o is 1 when DEPTH words are stored in standard mode, and 0 otherwise. In fall-through mode wr_stat_o is input-ready: 0 when the storage array holds DEPTH words, and 1 otherwise.
- R5: A write while the array is full is ignored. It does not change the stored words or the pointers.
- R6: A standard-mode read while empty is ignored. rdata_o keeps its value, and the next word written is the next word read.
- R7: almost_empty_o is 1 when the read-side count of words in the array is less than or equal to the almost-empty offset.
- R8: almost_full_o is 1 when the write-side count plus the almost-full offset is at least DEPTH.
- R9: half_full_o is 1 when the write-side count is greater than DEPTH/2.
- R10: On each write-clock edge with load_i and wr_en_i both high, one offset is taken from wdata_i[AW:0]. The first such edge sets the almost-empty offset and the second sets the almost-full offset. These edges do not write the array. The sequence restarts whenever load_i is low. Reset sets both offsets to 7.
- R11: rdata_o is zero while oe_i is low, and shows the output register while oe_i is high.
- R12: Reset clears both pointers and the output register. After reset, rd_stat_o is 1 in standard mode and 0 in fall-through mode. After reset, wr_stat_o is 0 in standard mode and 1 in fall-through mode. almost_empty_o is 1, and almost_full_o and half_full_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset for both domains, active low |
| ft_mode_i | input | 1 | 1 selects fall-through read timing, 0 selects standard; static |
| wr_en_i | input | 1 | Write enable |
| load_i | input | 1 | Offset load; with wr_en_i, steers wdata_i into the offset registers |
| wdata_i | input | DW | Write data, or offset value during a load |
| rd_en_i | input | 1 | Read enable |
| oe_i | input | 1 | Output enable for rdata_o |
| rdata_o | output | DW | Read data, zero when oe_i is low |
| rd_stat_o | output | 1 | Empty (standard mode) or output-ready (fall-through mode) |
| wr_stat_o | output | 1 | Full (standard mode) or input-ready (fall-through mode) |
| almost_empty_o | output | 1 | Programmable almost-empty flag |
| almost_full_o | output | 1 | Programmable almost-full flag |
| half_full_o | output | 1 | More than half of the depth is occupied |

## Verification
The bench measures the fall-through latency edge by edge on the read clock. A design with one synchronizer stage too few or too many would show the first word one edge early or one edge late. It fills the array to exactly DEPTH words and then writes once more, and reads back while empty. A pointer that moved on an ignored access would return an extra word or a stale word, or lose the ordering. Each programmable and half-full flag is checked one word below its threshold and one word above it, which exposes an off-by-one error in a comparison. The bench also loads new offsets and checks that the load cycles leave the array empty. A sequencer that stored the offset bytes as data, or captured the two offsets in the wrong order, would show this at the flags.

// File: rtl/xclk_fifo_pkg.sv
`timescale 1ns/1ps
package xclk_fifo_pkg;
  typedef enum logic {
    OFS_AE = 1'b0,
    OFS_AF = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/xclk_ptr_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray pointer; output converted to binary.
module xclk_ptr_sync #(
  parameter int PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_i;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_o[PW-1] = sync_q[PW-1];
    for (int i = PW-2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ sync_q[i];
  end
endmodule

// File: rtl/xclk_ram.sv
`timescale 1ns/1ps
module xclk_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/xclk_wr_ctrl.sv
`timescale 1ns/1ps
module xclk_wr_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter int AW      = 4,
  parameter int OFS_RST = 7
) (
  input  logic        wclk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        load_i,
  input  logic [AW:0] ofs_i,
  input  logic [AW:0] rptr_bin_i,
  output logic        we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0] wgray_o,
  output logic        full_o,
  output logic        almost_full_o,
  output logic        half_full_o,
  output logic [AW:0] ae_ofs_o
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW:0] DEPTH_X = (PW+1)'(DEPTH);

  logic [PW-1:0] wptr_q, wptr_nxt, wgray_q, wcount, af_ofs_q, ae_ofs_q;
  ofs_sel_e      sel_q;
  logic          load_go, push;

  assign wcount   = wptr_q - rptr_bin_i;
  assign full_o   = (wcount == PW'(DEPTH));
  assign load_go  = wr_en_i & load_i;
  assign push     = wr_en_i & ~load_i & ~full_o;
  assign wptr_nxt = wptr_q + 1'b1;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      wgray_q  <= '0;
      ae_ofs_q <= PW'(OFS_RST);
      af_ofs_q <= PW'(OFS_RST);
      sel_q    <= OFS_AE;
    end else begin
      if (push) begin
        wptr_q  <= wptr_nxt;
        wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      end
      if (load_go) begin
        if (sel_q == OFS_AE) begin
          ae_ofs_q <= ofs_i;
          sel_q    <= OFS_AF;
        end else begin
          af_ofs_q <= ofs_i;
          sel_q    <= OFS_AE;
        end
      end else if (!load_i) begin
        sel_q <= OFS_AE;
      end
    end
  end

  assign we_o          = push;
  assign waddr_o       = wptr_q[AW-1:0];
  assign wgray_o       = wgray_q;
  assign ae_ofs_o      = ae_ofs_q;
  assign almost_full_o = ({1'b0, wcount} + {1'b0, af_ofs_q}) >= DEPTH_X;
  assign half_full_o   = (wcount > PW'(DEPTH/2));

  // R1
  wgray_step_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  // R5
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> (wptr_q == $past(wptr_q)));
  // R10
  load_no_write_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    load_go |=> (wptr_q == $past(wptr_q)));
  // R4
  count_bound_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wcount <= PW'(DEPTH));
endmodule

// File: rtl/xclk_rd_ctrl.sv
`timescale 1ns/1ps
module xclk_rd_ctrl #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          ft_mode_i,
  input  logic          rd_en_i,
  input  logic [AW:0]   wptr_bin_i,
  input  logic [AW:0]   ae_ofs_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] dout_o,
  output logic          rd_stat_o,
  output logic          almost_empty_o
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rptr_q, rptr_nxt, rgray_q, rcount;
  logic [DW-1:0] dout_q;
  logic          valid_q, mem_empty, pop;

  assign rcount    = wptr_bin_i - rptr_q;
  assign mem_empty = (rcount == '0);
  assign rptr_nxt  = rptr_q + 1'b1;
  // Fall-through: refill the output stage whenever it is free or being taken.
  assign pop = ft_mode_i ? (~mem_empty & (~valid_q | rd_en_i))
                         : (rd_en_i & ~mem_empty);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (pop) begin
        rptr_q  <= rptr_nxt;
        rgray_q <= rptr_nxt ^ (rptr_nxt >> 1);
        dout_q  <= mem_rdata_i;
      end
      if (ft_mode_i) begin
        if (pop)          valid_q <= 1'b1;
        else if (rd_en_i) valid_q <= 1'b0;
      end
    end
  end

  assign raddr_o        = rptr_q[AW-1:0];
  assign rgray_o        = rgray_q;
  assign dout_o         = dout_q;
  assign rd_stat_o      = ft_mode_i ? valid_q : mem_empty;
  assign almost_empty_o = (rcount <= ae_ofs_i);

  // R1
  rgray_step_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
  // R6
  no_underflow_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!ft_mode_i && rd_en_i && mem_empty) |=> (rptr_q == $past(rptr_q) && dout_q == $past(dout_q)));
  // R3
  ft_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $fell(valid_q) |-> $past(rd_en_i));
  // R1
  rd_bound_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rcount <= PW'(DEPTH));
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
  parameter int DW      = 8,
  parameter int AW      = 4,
  parameter int OFS_RST = 7
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          ft_mode_i,
  input  logic          wr_en_i,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  input  logic          oe_i,
  output logic [DW-1:0] rdata_o,
  output logic          rd_stat_o,
  output logic          wr_stat_o,
  output logic          almost_empty_o,
  output logic          almost_full_o,
  output logic          half_full_o
);
  localparam int PW = AW + 1;

  logic          we, full;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wptr_rd, rptr_wr, ae_ofs;
  logic [DW-1:0] mem_rdata, dout;

  xclk_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk_i (wclk_i), .we_i (we), .waddr_i (waddr), .wdata_i (wdata_i),
    .raddr_i(raddr),  .rdata_o(mem_rdata)
  );

  xclk_wr_ctrl #(.AW(AW), .OFS_RST(OFS_RST)) u_wr (
    .wclk_i       (wclk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .load_i       (load_i),
    .ofs_i        (wdata_i[PW-1:0]),
    .rptr_bin_i   (rptr_wr),
    .we_o         (we),
    .waddr_o      (waddr),
    .wgray_o      (wgray),
    .full_o       (full),
    .almost_full_o(almost_full_o),
    .half_full_o  (half_full_o),
    .ae_ofs_o     (ae_ofs)
  );

  xclk_ptr_sync #(.PW(PW)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wgray), .bin_o(wptr_rd)
  );

  xclk_ptr_sync #(.PW(PW)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rgray), .bin_o(rptr_wr)
  );

  // Offsets are quasi-static: written only while the read side is idle.
  xclk_rd_ctrl #(.DW(DW), .AW(AW)) u_rd (
    .rclk_i        (rclk_i),
    .rst_ni        (rst_ni),
    .ft_mode_i     (ft_mode_i),
    .rd_en_i       (rd_en_i),
    .wptr_bin_i    (wptr_rd),
    .ae_ofs_i      (ae_ofs),
    .mem_rdata_i   (mem_rdata),
    .raddr_o       (raddr),
    .rgray_o       (rgray),
    .dout_o        (dout),
    .rd_stat_o     (rd_stat_o),
    .almost_empty_o(almost_empty_o)
  );

  assign wr_stat_o = ft_mode_i ? ~full : full;
  assign rdata_o   = oe_i ? dout : '0;

  // R11
  oe_zero_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !oe_i |-> (rdata_o == '0));
endmodule

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/1ps
module xclk_fifo_bench;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk, rclk, rst_n, ft_mode, wr_en, load, rd_en, oe;
  logic [DW-1:0] wdata, rdata;
  logic rd_stat, wr_stat, ae, af, hf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [DW-1:0] model_q[$];

  xclk_fifo #(.DW(DW), .AW(AW)) u_xclk_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .ft_mode_i(ft_mode),
    .wr_en_i(wr_en), .load_i(load), .wdata_i(wdata), .rd_en_i(rd_en),
    .oe_i(oe), .rdata_o(rdata), .rd_stat_o(rd_stat), .wr_stat_o(wr_stat),
    .almost_empty_o(ae), .almost_full_o(af), .half_full_o(hf)
  );

  // wclk rises at x.5 ns, rclk rises on whole ns: the edges never coincide.
  initial begin
    wclk = 0;
    forever #2.5 wclk = ~wclk;
  end
  initial begin
    rclk = 0;
    #0.5;
    forever #3.5 rclk = ~rclk;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(logic ft);
    @(posedge wclk); #1;
    rst_n = 0; ft_mode = ft; wr_en = 0; load = 0; rd_en = 0;
    model_q.delete();
    repeat (3) @(posedge wclk); #1;
    rst_n = 1;
    repeat (4) @(posedge rclk); #1;
  endtask

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (4) @(posedge wclk);
    #1;
  endtask

  task automatic wr_word(logic [DW-1:0] d, bit keep);
    @(posedge wclk); #1;
    wr_en = 1; wdata = d;
    @(posedge wclk); #1;
    wr_en = 0;
    if (keep) model_q.push_back(d);
  endtask

  task automatic rd_std(string req);
    logic [DW-1:0] exp;
    @(posedge rclk); #1;
    rd_en = 1;
    @(posedge rclk); #1;
    rd_en = 0;
    exp = model_q.pop_front();
    chk(req, rdata, exp);
  endtask

  task automatic rd_ft(string req);
    logic [DW-1:0] exp;
    exp = model_q.pop_front();
    chk(req, rdata, exp);
    chk(req, rd_stat, 1);
    @(posedge rclk); #1;
    rd_en = 1;
    @(posedge rclk); #1;
    rd_en = 0;
  endtask

  task automatic t_reset_std();
    chk("R12 empty", rd_stat, 1);
    chk("R12 full", wr_stat, 0);
    chk("R12 ae", ae, 1);
    chk("R12 af", af, 0);
    chk("R12 hf", hf, 0);
    chk("R12 rdata", rdata, 0);
  endtask

  task automatic t_order_std();
    for (int i = 0; i < 5; i++) wr_word(8'hA0 + 8'(i), 1);
    settle();
    chk("R2 not empty", rd_stat, 0);
    chk("R2 rdata before read", rdata, 0);
    for (int i = 0; i < 5; i++) rd_std("R1 order");
    settle();
    chk("R2 empty after drain", rd_stat, 1);
    chk("R2 hold", rdata, 8'hA4);
  endtask

  task automatic t_empty_read();
    for (int i = 0; i < 3; i++) begin
      @(posedge rclk); #1; rd_en = 1;
      @(posedge rclk); #1; rd_en = 0;
    end
    chk("R6 rdata kept", rdata, 8'hA4);
    chk("R6 still empty", rd_stat, 1);
    wr_word(8'h5A, 1);
    settle();
    rd_std("R6 next word");
  endtask

  task automatic t_levels();
    for (int i = 0; i < 7; i++) wr_word(8'h10 + 8'(i), 1);
    settle();
    chk("R7 ae at 7", ae, 1);
    chk("R8 af at 7", af, 0);
    chk("R9 hf at 7", hf, 0);
    wr_word(8'h17, 1);
    settle();
    chk("R7 ae at 8", ae, 0);
    chk("R8 af at 8", af, 0);
    chk("R9 hf at 8", hf, 0);
    wr_word(8'h18, 1);
    settle();
    chk("R8 af at 9", af, 1);
    chk("R9 hf at 9", hf, 1);
    chk("R4 not full at 9", wr_stat, 0);
    for (int i = 9; i < DEPTH; i++) wr_word(8'h10 + 8'(i), 1);
    settle();
    chk("R4 full", wr_stat, 1);
    wr_word(8'hEE, 0);
    settle();
    chk("R5 full kept", wr_stat, 1);
    for (int i = 0; i < DEPTH; i++) rd_std("R5 contents");
    settle();
    chk("R5 no extra word", rd_stat, 1);
    chk("R4 full clear", wr_stat, 0);
  endtask

  task automatic t_load();
    @(posedge wclk); #1;
    load = 1; wr_en = 1; wdata = 8'd3;
    @(posedge wclk); #1;
    wdata = 8'd2;
    @(posedge wclk); #1;
    load = 0; wr_en = 0;
    settle();
    chk("R10 no array write", rd_stat, 1);
    for (int i = 0; i < 3; i++) wr_word(8'h60 + 8'(i), 1);
    settle();
    chk("R10 ae ofs 3 at 3", ae, 1);
    wr_word(8'h63, 1);
    settle();
    chk("R10 ae ofs 3 at 4", ae, 0);
    for (int i = 4; i < 13; i++) wr_word(8'h60 + 8'(i), 1);
    settle();
    chk("R10 af ofs 2 at 13", af, 0);
    wr_word(8'h6D, 1);
    settle();
    chk("R10 af ofs 2 at 14", af, 1);
    for (int i = 0; i < 14; i++) rd_std("R10 data after load");
    settle();
  endtask

  task automatic t_oe();
    wr_word(8'h3C, 1);
    settle();
    rd_std("R11 read");
    oe = 0; #1;
    chk("R11 disabled", rdata, 0);
    oe = 1; #1;
    chk("R11 enabled", rdata, 8'h3C);
  endtask

  task automatic t_ft();
    do_reset(1);
    chk("R12 ft not ready", rd_stat, 0);
    chk("R12 ft input ready", wr_stat, 1);
    @(posedge wclk); #1;
    wr_en = 1; wdata = 8'h11;
    model_q.push_back(8'h11);
    @(posedge wclk);
    fork
      begin #1; wr_en = 0; end
    join_none
    for (int e = 1; e <= 3; e++) begin
      @(posedge rclk); #1;
      if (e < 3) chk("R3 early edge", rd_stat, 0);
      else begin
        chk("R3 third edge ready", rd_stat, 1);
        chk("R3 third edge data", rdata, 8'h11);
      end
    end
    for (int i = 0; i < DEPTH; i++) wr_word(8'h20 + 8'(i), 1);
    settle();
    chk("R4 ft input not ready", wr_stat, 0);
    for (int i = 0; i <= DEPTH; i++) rd_ft("R1 ft order");
    settle();
    chk("R3 ft drained", rd_stat, 0);
    chk("R4 ft input ready", wr_stat, 1);
  endtask

  initial begin
    rst_n = 0; ft_mode = 0; wr_en = 0; load = 0; rd_en = 0; oe = 1; wdata = '0;
    do_reset(0);
    t_reset_std();
    t_order_std();
    t_empty_read();
    t_levels();
    t_load();
    t_oe();
    t_ft();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule